// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets two processor cores trade short messages through a set of independent channels on a shared synchronous register bus. Each channel holds a control word and four payload words. A sender fills the payload and then writes the control word with its top bit set. That write marks the channel as holding a message and raises the channel's interrupt flag. The receiver reads the words and clears the flags by writing ones to the channel status register. Clearing the data-pending flag hands the channel back to the sender.

A packed register shows the two flags of every channel in one read. Each destination core has its own per-channel mask that routes channel interrupts to that core's interrupt output. Every mask bit has a sticky lock bit. Once the lock is set, the mask bit no longer changes. Writes that arrive while a message is still pending are dropped and recorded in an overrun flag.

Top module: `ipc_mailbox`

## Requirements
- R1: With 8 channels, channel c occupies word addresses c*8 to c*8+7. Offset 0 is the control word, offsets 1 to 4 are payload words 0 to 3, and offset 5 is status. Read data for an address appears on `rd_data` one clock after the address is presented.
- R2: A control write with bit 31 set, made while data-pending is clear, sets status bit 0 (data-pending) and status bit 1 (interrupt-pending). A control write with bit 31 clear only stores the control bits.
- R3: A control word read returns the stored bits with bit 31 always 0.
- R4: Status bits 0 (data-pending), 1 (interrupt-pending) and 2 (overrun) are each cleared by writing 1 to that bit position. Writing 0 to a bit leaves it unchanged.
- R5: A control or payload write to a channel whose data-pending bit is set leaves the stored words unchanged and sets status bit 2 (overrun).
- R6: Control and payload writes are accepted whenever data-pending is clear, even while interrupt-pending is still set.
- R7: The all-channel status register sits at word address 64. Channel i appears at bits [2i+1:2i], with data-pending at bit 2i and interrupt-pending at bit 2i+1.
- R8: The interrupt mask for destination d sits at address 65+2d, one bit per channel. It resets to all ones. A set bit blocks that channel from destination d.
- R9: The lock register for destination d sits at address 66+2d. Writing 1 to a lock bit sets it, and only reset clears it. A mask bit whose lock is set keeps its value through mask writes.
- R10: `irq_o[d]` equals the OR of all interrupt-pending flags not masked for destination d, as they stood one clock earlier.
- R11: After reset, all channel status bits are 0, all masks read all ones, all locks read 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after `addr` |
| irq_o | output | 2 | One interrupt line per destination core |

## Verification
The handshake is tried in four ways:
- A full send with the trigger bit set, which must raise both flags.
- A control write without the trigger bit, which must store the word and leave the flags alone.
- Writes into a busy channel, which must leave the stored words intact and set only the overrun flag.
- A payload write after clearing data-pending alone, which must be accepted even with the interrupt flag still set.

Routing is tried with unmasked and masked channels, and with locked mask bits holding both a 1 and a 0. Locked bits must keep their values while their unlocked neighbours change. Channels 0 and 7 are triggered together so the packed status register is checked at both ends of its bit range.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd5;
  localparam int STAT_PEND = 0;
  localparam int STAT_IRQ  = 1;
  localparam int STAT_OVR  = 2;

  function automatic logic is_payload_off(input logic [2:0] off);
    return (off >= 3'd1) && (off <= 3'd4);
  endfunction
endpackage

// File: rtl/mbx_payload_ram.sv
module mbx_payload_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-2:0] ctrl_q,
  output logic          pend_q,
  output logic          irq_q,
  output logic          ovr_q
);
  logic busy_hit;
  assign busy_hit = we && pend_q && (off == OFF_CTRL || is_payload_off(off));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (busy_hit) begin
      ovr_q <= 1'b1;
    end else if (we && off == OFF_CTRL) begin
      ctrl_q <= wdata[DW-2:0];
      if (wdata[DW-1]) begin
        pend_q <= 1'b1;
        irq_q  <= 1'b1;
      end
    end else if (we && off == OFF_STAT) begin
      if (wdata[STAT_PEND]) pend_q <= 1'b0;
      if (wdata[STAT_IRQ])  irq_q  <= 1'b0;
      if (wdata[STAT_OVR])  ovr_q  <= 1'b0;
    end
  end

  assert_trigger_sets_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (we && off == OFF_CTRL && !pend_q && wdata[DW-1]) |=> (pend_q && irq_q));

  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (we && pend_q && off <= 3'd4) |=> (ovr_q && $stable(ctrl_q)));

  assert_w1c_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (we && off == OFF_STAT && wdata[STAT_PEND]) |=> !pend_q);
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mask_we,
  input  logic           lock_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] irqp,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] lock_q,
  output logic           irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      lock_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (mask_we && !lock_q[i]) mask_q[i] <= wdata[i];
      end
      if (lock_we) lock_q <= lock_q | wdata;
      irq_o <= |(irqp & ~mask_q);
    end
  end

  assert_lock_holds_mask_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & $past(lock_q)) == '0));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lock_q) & ~lock_q) == '0));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ((irqp & ~mask_q) == '0) |=> !irq_o);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NDEST = 2,
  parameter int DW    = 32,
  localparam int CH_AW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW    = CH_AW + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [NDEST-1:0] irq_o
);
  localparam int GOFF_W = CH_AW + 3;

  logic              glob;
  logic [CH_AW-1:0]  ch;
  logic [2:0]        off;
  logic [GOFF_W-1:0] goff;
  logic              ch_ok;
  logic [2:0]        offm1;

  assign glob  = addr[AW-1];
  assign ch    = addr[CH_AW+2:3];
  assign off   = addr[2:0];
  assign goff  = addr[GOFF_W-1:0];
  assign ch_ok = int'(ch) < NCH;
  assign offm1 = off - 3'd1;

  logic [NCH-1:0] pend, irqp, ovr;
  logic [DW-2:0]  ctrl [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mbx_channel #(.DW(DW)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && !glob && ch_ok && int'(ch) == c),
      .off   (off),
      .wdata (wr_data),
      .ctrl_q(ctrl[c]),
      .pend_q(pend[c]),
      .irq_q (irqp[c]),
      .ovr_q (ovr[c])
    );
  end

  logic            ram_we;
  logic [DW-1:0]   ram_q;
  logic [CH_AW+1:0] ram_addr;

  assign ram_addr = {ch, offm1[1:0]};
  assign ram_we   = wr_en && !glob && ch_ok && is_payload_off(off) && !pend[ch];

  mbx_payload_ram #(.DW(DW), .DEPTH(4 << CH_AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(wr_data),
    .rdata(ram_q)
  );

  logic [NCH-1:0] mask [NDEST];
  logic [NCH-1:0] lock [NDEST];

  for (genvar d = 0; d < NDEST; d++) begin : g_dest
    mbx_irq_route #(.NCH(NCH)) u_route (
      .clk    (clk),
      .rst    (rst),
      .mask_we(wr_en && glob && int'(goff) == 1 + 2 * d),
      .lock_we(wr_en && glob && int'(goff) == 2 + 2 * d),
      .wdata  (wr_data[NCH-1:0]),
      .irqp   (irqp),
      .mask_q (mask[d]),
      .lock_q (lock[d]),
      .irq_o  (irq_o[d])
    );
  end

  logic [DW-1:0] reg_rd, reg_rd_q;
  logic          from_ram_q;

  always_comb begin
    reg_rd = '0;
    if (glob) begin
      if (goff == '0) begin
        for (int i = 0; i < NCH; i++) begin
          reg_rd[2*i]   = pend[i];
          reg_rd[2*i+1] = irqp[i];
        end
      end
      for (int d = 0; d < NDEST; d++) begin
        if (int'(goff) == 1 + 2 * d) reg_rd[NCH-1:0] = mask[d];
        if (int'(goff) == 2 + 2 * d) reg_rd[NCH-1:0] = lock[d];
      end
    end else if (ch_ok) begin
      if (off == OFF_CTRL) reg_rd = {1'b0, ctrl[ch]};
      if (off == OFF_STAT) begin
        reg_rd[STAT_PEND] = pend[ch];
        reg_rd[STAT_IRQ]  = irqp[ch];
        reg_rd[STAT_OVR]  = ovr[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q   <= '0;
      from_ram_q <= 1'b0;
    end else begin
      reg_rd_q   <= reg_rd;
      from_ram_q <= !glob && ch_ok && is_payload_off(off);
    end
  end

  assign rd_data = from_ram_q ? ram_q : reg_rd_q;

  assert_ctrl_top_bit_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !from_ram_q |-> !reg_rd_q[DW-1]);
endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  localparam int AW = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] chan(input int c, input int o);
    return AW'(c * 8 + o);
  endfunction

  localparam logic [AW-1:0] ALLST = 7'd64;
  localparam logic [AW-1:0] MASK0 = 7'd65;
  localparam logic [AW-1:0] LOCK0 = 7'd66;
  localparam logic [AW-1:0] MASK1 = 7'd67;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; wr_en = 1'b0;
    @(negedge clk); chk(rd_data, exp, req);
  endtask

  task automatic test_reset;
    chk({30'd0, irq_o}, 32'd0, "R11 irq after reset");
    rd_chk(chan(0, 5), 32'd0, "R11 status ch0");
    rd_chk(ALLST, 32'd0, "R11 all status");
    rd_chk(MASK0, 32'hFF, "R11 mask d0");
    rd_chk(MASK1, 32'hFF, "R11 mask d1");
    rd_chk(LOCK0, 32'd0, "R11 lock d0");
  endtask

  task automatic test_send;
    for (int i = 1; i <= 4; i++) wr(chan(2, i), 32'h1111_1111 * i);
    wr(chan(2, 0), 32'h8000_00A5);
    rd_chk(chan(2, 5), 32'd3, "R2 trigger flags");
    rd_chk(chan(2, 0), 32'h0000_00A5, "R3 ctrl top bit masked");
    for (int i = 1; i <= 4; i++) rd_chk(chan(2, i), 32'h1111_1111 * i, "R1 payload readback");
    rd_chk(ALLST, 32'h30, "R7 packed ch2");
  endtask

  task automatic test_overrun;
    wr(chan(2, 1), 32'hDEAD_BEEF);
    wr(chan(2, 0), 32'h8000_0077);
    rd_chk(chan(2, 1), 32'h1111_1111, "R5 payload kept");
    rd_chk(chan(2, 0), 32'h0000_00A5, "R5 ctrl kept");
    rd_chk(chan(2, 5), 32'd7, "R5 overrun set");
    wr(chan(2, 5), 32'd4);
    rd_chk(chan(2, 5), 32'd3, "R4 clear overrun only");
  endtask

  task automatic test_consume;
    wr(chan(2, 5), 32'd1);
    rd_chk(chan(2, 5), 32'd2, "R4 clear pending only");
    wr(chan(2, 1), 32'h2222_0000);
    rd_chk(chan(2, 1), 32'h2222_0000, "R6 write with irq set");
    rd_chk(chan(2, 5), 32'd2, "R6 no overrun");
    wr(chan(2, 5), 32'd2);
    rd_chk(chan(2, 5), 32'd0, "R4 clear irq");
  endtask

  task automatic test_no_trigger;
    wr(chan(2, 0), 32'h0000_0033);
    rd_chk(chan(2, 5), 32'd0, "R2 no trigger");
    rd_chk(chan(2, 0), 32'h0000_0033, "R2 ctrl stored");
  endtask

  task automatic test_route;
    wr(MASK0, 32'hF7);
    wr(chan(3, 0), 32'h8000_0001);
    chk({30'd0, irq_o}, 32'd0, "R10 one cycle latency");
    @(negedge clk);
    chk({30'd0, irq_o}, 32'd1, "R8 unmasked d0 only");
    wr(chan(3, 5), 32'd3);
    @(negedge clk);
    chk({30'd0, irq_o}, 32'd0, "R10 irq drops");
  endtask

  task automatic test_lock;
    wr(LOCK0, 32'h09);
    wr(MASK0, 32'h00);
    rd_chk(MASK0, 32'h01, "R9 locked bits hold");
    wr(LOCK0, 32'h00);
    rd_chk(LOCK0, 32'h09, "R9 lock sticky");
    wr(chan(0, 0), 32'h8000_0000);
    @(negedge clk);
    chk({30'd0, irq_o}, 32'd0, "R8 locked mask blocks");
    wr(chan(7, 0), 32'h8000_0000);
    @(negedge clk);
    chk({30'd0, irq_o}, 32'd1, "R10 ch7 to d0");
    rd_chk(ALLST, 32'h0000_C003, "R7 packed ch0 ch7");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset;
    test_send;
    test_overrun;
    test_consume;
    test_no_trigger;
    test_route;
    test_lock;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule